// File: doc/BRIEF.md
# Page Table Entry Leaf Checker

This block judges one page table entry fetched by a hardware page walker. On a start pulse it classifies the entry as a fault, as a pointer to the next table level, or as a leaf. It also extracts the physical page number and works out the entry value with its accessed and dirty flags brought up to date. When a leaf's flags must change, the block asks for a hardware write-back. If that write-back is not enabled, it reports a fault.

Two features are governed by enables: page memory attributes, and hardware accessed/dirty maintenance. Each has a machine-level enable and a hypervisor-level enable. The machine-level bit alone decides, except in one case: when the walk is the first stage of a two-stage translation and virtualization is active, the machine-level bit is ANDed with the hypervisor-level bit. A 32/64-bit select picks the entry width. In 32-bit mode only the lower half of the entry counts, and the memory-attribute check is skipped.

When a permitted update is needed, the block raises an update request and holds it until the walker acknowledges that the atomic write is done. Only then does it signal completion. The walk sequencing, the memory port and the permission checks other than accessed/dirty belong to the surrounding walker.

Top module: `ptechk_top`

## Requirements
- R1: After reset, done_o and upd_req_o are low.
- R2: An entry with bit 0 (valid) clear gives fault_o=1 and descend_o=0. done_o rises in the cycle after the start edge.
- R3: In 64-bit mode, a nonzero attribute field in bits 62:61 gives a fault while the effective attribute enable is off. In 32-bit mode this check is skipped, and bits 63:32 of the entry are treated as zero.
- R4: The effective attribute enable and the effective update enable each equal the machine-level bit. When both the first-of-two-stages flag and the virtualization flag are set, each is ANDed with its hypervisor-level bit.
- R5: A valid, non-faulting entry whose bits 3:1 (read, write, execute) are all zero gives descend_o=1 and fault_o=0, with no update request.
- R6: ppn_o is bits 53:10 of the entry (upper ten bits cleared) in 64-bit mode when the effective attribute enable or napot_en_i is set. Otherwise ppn_o is the whole entry shifted right by 10.
- R7: upd_pte_o is the entry with bit 6 (accessed) set, and also bit 7 (dirty) set when is_store_i is high.
- R8: A leaf whose upd_pte_o differs from the entry gives a fault, with no update request, when the effective update enable is off.
- R9: A leaf needing an update with the update enable on raises upd_req_o from the cycle after start. upd_req_o holds until upd_done_i is sampled high. done_o follows in the next cycle, with fault_o=0.
- R10: A leaf that needs no update completes in the cycle after start, with fault_o=0 and no request.
- R11: A start pulse while a check is in progress is ignored. The outputs stay those of the check in progress, and no extra done_o pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_valid_i | input | 1 | Start pulse; sampled when idle |
| pte_i | input | PTE_W | Fetched entry |
| is_store_i | input | 1 | Access is a store |
| xlen64_i | input | 1 | 1: 64-bit entry, 0: 32-bit entry |
| napot_en_i | input | 1 | Contiguous-page feature present |
| m_attr_en_i | input | 1 | Machine-level attribute enable |
| m_adupd_en_i | input | 1 | Machine-level hardware A/D update enable |
| h_attr_en_i | input | 1 | Hypervisor-level attribute enable |
| h_adupd_en_i | input | 1 | Hypervisor-level hardware A/D update enable |
| stage1_of_two_i | input | 1 | Walk is first stage of a two-stage translation |
| virt_on_i | input | 1 | Virtualization mode active |
| upd_done_i | input | 1 | Walker finished the atomic write-back |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Entry causes a fault |
| descend_o | output | 1 | Entry points to the next level |
| ppn_o | output | PTE_W-PPN_OFS | Extracted page number |
| upd_req_o | output | 1 | Write-back of upd_pte_o requested |
| upd_pte_o | output | PTE_W | Entry with accessed/dirty applied |

## Verification
The bench builds the block with its default parameters: a 64-bit entry and a 10-bit page offset. This places the attribute field at bits 62:61 and the reserved region at bits 63:54, so both the masked and the unmasked page-number paths are visible.

With those values, the bench sweeps every combination of the six enable and mode flags. It crosses them with valid, pointer and leaf entries, all four accessed/dirty starting states, load and store, zero and nonzero attribute fields, both widths, and the contiguous-page flag. It varies the acknowledge delay in every update case. A final directed case issues a start while an update is pending.

// File: rtl/ptechk_pkg.sv
package ptechk_pkg;

    // Flag positions that neighbouring walker logic decodes
    localparam int unsigned VLD_BIT = 0;
    localparam int unsigned RD_BIT  = 1;
    localparam int unsigned EX_BIT  = 3;
    localparam int unsigned ACC_BIT = 6;
    localparam int unsigned DRT_BIT = 7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UPD  = 2'd1,
        ST_FIN  = 2'd2
    } chk_state_e;

endpackage

// File: rtl/ptechk_enable.sv
module ptechk_enable (
    input  logic m_attr_en_i,
    input  logic m_adupd_en_i,
    input  logic h_attr_en_i,
    input  logic h_adupd_en_i,
    input  logic stage1_of_two_i,
    input  logic virt_on_i,
    output logic attr_en_o,
    output logic adupd_en_o
);
    logic guest_walk;

    always_comb begin
        guest_walk = stage1_of_two_i && virt_on_i;
        attr_en_o  = m_attr_en_i  && (!guest_walk || h_attr_en_i);
        adupd_en_o = m_adupd_en_i && (!guest_walk || h_adupd_en_i);
    end
endmodule

// File: rtl/ptechk_classify.sv
module ptechk_classify
    import ptechk_pkg::*;
#(
    parameter int unsigned PTE_W    = 64,
    parameter int unsigned PPN_OFS  = 10,
    parameter int unsigned RSV_LSB  = 54,
    parameter int unsigned ATTR_LSB = 61,
    parameter int unsigned ATTR_W   = 2
) (
    input  logic [PTE_W-1:0]         pte_i,
    input  logic                     xlen64_i,
    input  logic                     attr_en_i,
    input  logic                     napot_en_i,
    output logic                     invalid_o,
    output logic                     attr_flt_o,
    output logic                     pointer_o,
    output logic [PTE_W-PPN_OFS-1:0] ppn_o
);
    localparam int unsigned KEEP_W = RSV_LSB;
    localparam int unsigned DROP_W = PTE_W - RSV_LSB;

    logic [PTE_W-1:0] keep_mask;
    logic [PTE_W-1:0] src;
    logic             use_mask;

    always_comb begin
        keep_mask  = {{DROP_W{1'b0}}, {KEEP_W{1'b1}}};
        invalid_o  = !pte_i[VLD_BIT];
        attr_flt_o = xlen64_i && !attr_en_i && (pte_i[ATTR_LSB +: ATTR_W] != '0);
        pointer_o  = (pte_i[EX_BIT:RD_BIT] == '0);
        use_mask   = xlen64_i && (attr_en_i || napot_en_i);
        src        = use_mask ? (pte_i & keep_mask) : pte_i;
        ppn_o      = src[PTE_W-1:PPN_OFS];
    end
endmodule

// File: rtl/ptechk_adupd.sv
module ptechk_adupd
    import ptechk_pkg::*;
#(
    parameter int unsigned PTE_W = 64
) (
    input  logic [PTE_W-1:0] pte_i,
    input  logic             is_store_i,
    output logic [PTE_W-1:0] new_pte_o,
    output logic             changed_o
);
    logic [PTE_W-1:0] set_bits;

    always_comb begin
        set_bits          = '0;
        set_bits[ACC_BIT] = 1'b1;
        set_bits[DRT_BIT] = is_store_i;
        new_pte_o         = pte_i | set_bits;
        changed_o         = (new_pte_o != pte_i);
    end
endmodule

// File: rtl/ptechk_top.sv
module ptechk_top
    import ptechk_pkg::*;
#(
    parameter int unsigned PTE_W    = 64,
    parameter int unsigned HALF_W   = 32,
    parameter int unsigned PPN_OFS  = 10,
    parameter int unsigned RSV_LSB  = 54,
    parameter int unsigned ATTR_LSB = 61,
    parameter int unsigned ATTR_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     chk_valid_i,
    input  logic [PTE_W-1:0]         pte_i,
    input  logic                     is_store_i,
    input  logic                     xlen64_i,
    input  logic                     napot_en_i,
    input  logic                     m_attr_en_i,
    input  logic                     m_adupd_en_i,
    input  logic                     h_attr_en_i,
    input  logic                     h_adupd_en_i,
    input  logic                     stage1_of_two_i,
    input  logic                     virt_on_i,
    input  logic                     upd_done_i,
    output logic                     done_o,
    output logic                     fault_o,
    output logic                     descend_o,
    output logic [PTE_W-PPN_OFS-1:0] ppn_o,
    output logic                     upd_req_o,
    output logic [PTE_W-1:0]         upd_pte_o
);
    localparam int unsigned PPN_W = PTE_W - PPN_OFS;
    localparam int unsigned HI_W  = PTE_W - HALF_W;

    typedef struct packed {
        chk_state_e       state;
        logic             fault;
        logic             descend;
        logic [PPN_W-1:0] ppn;
        logic [PTE_W-1:0] upd_pte;
    } chk_regs_t;

    chk_regs_t r_d, r_q;

    logic             attr_en, adupd_en;
    logic [PTE_W-1:0] pte_eff;
    logic             invalid, attr_flt, pointer;
    logic [PPN_W-1:0] ppn_calc;
    logic [PTE_W-1:0] new_pte;
    logic             changed;

    // 32-bit mode: only the lower half of the entry exists
    assign pte_eff = xlen64_i ? pte_i : {{HI_W{1'b0}}, pte_i[HALF_W-1:0]};

    ptechk_enable u_enable (
        .m_attr_en_i    (m_attr_en_i),
        .m_adupd_en_i   (m_adupd_en_i),
        .h_attr_en_i    (h_attr_en_i),
        .h_adupd_en_i   (h_adupd_en_i),
        .stage1_of_two_i(stage1_of_two_i),
        .virt_on_i      (virt_on_i),
        .attr_en_o      (attr_en),
        .adupd_en_o     (adupd_en)
    );

    ptechk_classify #(
        .PTE_W   (PTE_W),
        .PPN_OFS (PPN_OFS),
        .RSV_LSB (RSV_LSB),
        .ATTR_LSB(ATTR_LSB),
        .ATTR_W  (ATTR_W)
    ) u_classify (
        .pte_i     (pte_eff),
        .xlen64_i  (xlen64_i),
        .attr_en_i (attr_en),
        .napot_en_i(napot_en_i),
        .invalid_o (invalid),
        .attr_flt_o(attr_flt),
        .pointer_o (pointer),
        .ppn_o     (ppn_calc)
    );

    ptechk_adupd #(
        .PTE_W(PTE_W)
    ) u_adupd (
        .pte_i     (pte_eff),
        .is_store_i(is_store_i),
        .new_pte_o (new_pte),
        .changed_o (changed)
    );

    always_comb begin
        logic early_flt;
        logic leaf;
        r_d       = r_q;
        early_flt = invalid || attr_flt;
        leaf      = !early_flt && !pointer;
        unique case (r_q.state)
            ST_IDLE: begin
                if (chk_valid_i) begin
                    r_d.fault   = early_flt || (leaf && changed && !adupd_en);
                    r_d.descend = !early_flt && pointer;
                    r_d.ppn     = ppn_calc;
                    r_d.upd_pte = new_pte;
                    r_d.state   = (leaf && changed && adupd_en) ? ST_UPD : ST_FIN;
                end
            end
            ST_UPD: begin
                if (upd_done_i) begin
                    r_d.state = ST_FIN;
                end
            end
            ST_FIN: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, fault: 1'b0, descend: 1'b0, ppn: '0, upd_pte: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o    = (r_q.state == ST_FIN);
    assign upd_req_o = (r_q.state == ST_UPD);
    assign fault_o   = r_q.fault;
    assign descend_o = r_q.descend;
    assign ppn_o     = r_q.ppn;
    assign upd_pte_o = r_q.upd_pte;
endmodule

// File: rtl/ptechk_checker.sv
module ptechk_checker #(
    parameter int unsigned PTE_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chk_valid_i,
    input logic             upd_done_i,
    input logic             done_o,
    input logic             fault_o,
    input logic             descend_o,
    input logic             upd_req_o,
    input logic [PTE_W-1:0] upd_pte_o
);
    // R9: request persists until acknowledged
    a_r9_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        upd_req_o && !upd_done_i |=> upd_req_o);

    // R9: acknowledge leads to completion next cycle
    a_r9_ack_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        upd_req_o && upd_done_i |=> done_o && !upd_req_o);

    // R8: a pending write-back never carries a fault
    a_r8_req_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        upd_req_o |-> !fault_o);

    // R5: pointer and fault are exclusive at completion
    a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(fault_o && descend_o));

    // R11: completion is a single-cycle pulse
    a_r11_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11: a new start during a pending update leaves its value untouched
    a_r11_busy_stable: assert property (@(posedge clk) disable iff (!rst_n)
        upd_req_o && chk_valid_i |=> $stable(upd_pte_o));

    // R1: request and done never overlap
    a_r1_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && upd_req_o));
endmodule

bind ptechk_top ptechk_checker #(.PTE_W(PTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chk_valid_i(chk_valid_i),
    .upd_done_i (upd_done_i),
    .done_o     (done_o),
    .fault_o    (fault_o),
    .descend_o  (descend_o),
    .upd_req_o  (upd_req_o),
    .upd_pte_o  (upd_pte_o)
);

// File: tb/ptechk_top_tb_top.sv
module ptechk_top_tb_top;
    localparam int unsigned PTE_W = 64;
    localparam int unsigned PPN_W = 54;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             chk_valid_i = 1'b0;
    logic [PTE_W-1:0] pte_i = '0;
    logic             is_store_i = 1'b0, xlen64_i = 1'b1, napot_en_i = 1'b0;
    logic             m_attr_en_i = 1'b0, m_adupd_en_i = 1'b0;
    logic             h_attr_en_i = 1'b0, h_adupd_en_i = 1'b0;
    logic             stage1_of_two_i = 1'b0, virt_on_i = 1'b0;
    logic             upd_done_i = 1'b0;
    logic             done_o, fault_o, descend_o, upd_req_o;
    logic [PPN_W-1:0] ppn_o;
    logic [PTE_W-1:0] upd_pte_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ptechk_top dut_i (
        .clk(clk), .rst_n(rst_n), .chk_valid_i(chk_valid_i), .pte_i(pte_i),
        .is_store_i(is_store_i), .xlen64_i(xlen64_i), .napot_en_i(napot_en_i),
        .m_attr_en_i(m_attr_en_i), .m_adupd_en_i(m_adupd_en_i),
        .h_attr_en_i(h_attr_en_i), .h_adupd_en_i(h_adupd_en_i),
        .stage1_of_two_i(stage1_of_two_i), .virt_on_i(virt_on_i),
        .upd_done_i(upd_done_i), .done_o(done_o), .fault_o(fault_o),
        .descend_o(descend_o), .ppn_o(ppn_o), .upd_req_o(upd_req_o),
        .upd_pte_o(upd_pte_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // One full check; expected results computed from the requirements
    task automatic run_case(input logic [63:0] pte, input bit st, input bit x64, input bit np,
                            input logic [5:0] fl, input int ack_dly);
        logic [63:0] pe, nw, eppn;
        bit pb, ha, inv, pf, ptr, need, efault, edesc, eupd, g;
        m_attr_en_i = fl[0]; m_adupd_en_i = fl[1]; h_attr_en_i = fl[2];
        h_adupd_en_i = fl[3]; stage1_of_two_i = fl[4]; virt_on_i = fl[5];
        g    = fl[4] && fl[5];
        pb   = fl[0] && (!g || fl[2]);                      // R4
        ha   = fl[1] && (!g || fl[3]);                      // R4
        pe   = x64 ? pte : {32'h0, pte[31:0]};
        inv  = !pe[0];                                      // R2
        pf   = x64 && !pb && (pe[62:61] != 2'b00);          // R3
        ptr  = (pe[3:1] == 3'b000);                         // R5
        nw   = pe | 64'h40 | (st ? 64'h80 : 64'h0);         // R7
        need = (nw != pe);
        efault = inv || pf || (!ptr && need && !ha);        // R8
        edesc  = !inv && !pf && ptr;
        eupd   = !inv && !pf && !ptr && need && ha;         // R9
        eppn   = (x64 && (pb || np)) ? ((pe & 64'h003F_FFFF_FFFF_FFFF) >> 10) : (pe >> 10); // R6
        pte_i = pte; is_store_i = st; xlen64_i = x64; napot_en_i = np;
        chk_valid_i = 1'b1;
        @(negedge clk);
        chk_valid_i = 1'b0;
        chk(upd_req_o == eupd, "R9 request after start", 64'(upd_req_o), 64'(eupd));
        if (eupd) begin
            for (int k = 0; k < ack_dly; k++) begin
                @(negedge clk);
                chk(upd_req_o && !done_o, "R9 request held", 64'(upd_req_o), 64'h1);
            end
            chk(upd_pte_o == nw, "R7 write-back value", upd_pte_o, nw);
            upd_done_i = 1'b1;
            @(negedge clk);
            upd_done_i = 1'b0;
        end
        chk(done_o == 1'b1, eupd ? "R9 done after ack" : "R10/R2 done latency", 64'(done_o), 64'h1);
        chk(!upd_req_o, "R9 request dropped", 64'(upd_req_o), 64'h0);
        chk(fault_o == efault, "R2/R3/R8 fault", 64'(fault_o), 64'(efault));
        chk(descend_o == edesc, "R5 descend", 64'(descend_o), 64'(edesc));
        chk(64'(ppn_o) == eppn, "R6 ppn", 64'(ppn_o), eppn);
        chk(upd_pte_o == nw, "R7 updated entry", upd_pte_o, nw);
        @(negedge clk);
        chk(!done_o, "R11 single done pulse", 64'(done_o), 64'h0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
        finish_run();
    end

    initial begin
        logic [63:0] base, low;
        int idx = 0;
        base = 64'h8040_1234_5678_9C00;
        repeat (3) @(negedge clk);
        chk(!done_o && !upd_req_o, "R1 reset outputs", {62'h0, done_o, upd_req_o}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done_o && !upd_req_o, "R1 idle after reset", {62'h0, done_o, upd_req_o}, 64'h0);

        for (int fl = 0; fl < 64; fl++)
            for (int kind = 0; kind < 4; kind++)
                for (int ad = 0; ad < 4; ad++)
                    for (int st = 0; st < 2; st++)
                        for (int at = 0; at < 2; at++)
                            for (int x = 0; x < 2; x++)
                                for (int np = 0; np < 2; np++) begin
                                    case (kind)
                                        0: low = 64'h0E;     // invalid
                                        1: low = 64'h01;     // pointer
                                        2: low = 64'h03;     // read-only leaf
                                        default: low = 64'h0F;
                                    endcase
                                    low = low | (64'(ad) << 6);
                                    run_case(base | low | (at[0] ? 64'h2000_0000_0000_0000 : 64'h0)
                                             | 64'h0000_0000_8000_0000,
                                             st[0], x[0], np[0], 6'(fl), idx % 3);
                                    idx++;
                                end

        // R11: start while an update is pending is ignored
        m_adupd_en_i = 1'b1; stage1_of_two_i = 1'b0; virt_on_i = 1'b0;
        m_attr_en_i = 1'b1; xlen64_i = 1'b1; is_store_i = 1'b1; napot_en_i = 1'b0;
        pte_i = 64'h0000_0000_0001_0007;
        chk_valid_i = 1'b1;
        @(negedge clk);
        chk_valid_i = 1'b0;
        chk(upd_req_o, "R11 first check pending", 64'(upd_req_o), 64'h1);
        pte_i = 64'h0000_0000_0002_0000;
        chk_valid_i = 1'b1;
        @(negedge clk);
        chk_valid_i = 1'b0;
        chk(upd_req_o && !done_o, "R11 busy start ignored", 64'(upd_req_o), 64'h1);
        chk(upd_pte_o == 64'h0000_0000_0001_00C7, "R11 value kept", upd_pte_o, 64'h0000_0000_0001_00C7);
        upd_done_i = 1'b1;
        @(negedge clk);
        upd_done_i = 1'b0;
        chk(done_o && !fault_o, "R11 first check completes", {62'h0, done_o, fault_o}, 64'h2);
        chk(64'(ppn_o) == 64'h40, "R11 ppn of first entry", 64'(ppn_o), 64'h40);
        @(negedge clk);
        @(negedge clk);
        chk(!done_o && !upd_req_o, "R11 no extra completion", {62'h0, done_o, upd_req_o}, 64'h0);
        finish_run();
    end
endmodule